// File: doc/BRIEF.md
# Selectable-Source Interrupt Generator with Change-of-State Detection

This block raises two independent interrupt requests for a digital input card. Each request line selects one of four causes through a 2-bit code: a level change on any enabled channel of two 24-bit input groups, a two-pin interlock edge rule, a falling edge on one control pin, or a terminal pulse from an external event counter or timer. A request, once raised, is held until software writes the clear address. Edges that arrive while a request is held are dropped, not queued.

All monitored inputs pass through a two-stage synchronizer before edge detection. Software programs the block through a simple write port. The two held requests are exposed as a 2-bit status vector, and their OR drives the single host interrupt.

Top module: `sel_irq_gen`

## Requirements
- R1: After reset, `pend` and `irq` are 0, both source codes are 00 and every change-of-state enable bit is 0.
- R2: A write to address 0x60 + 4*g (g = 0..3) loads `wr_data[23:0]` as the per-channel enable mask of input group g, where group g occupies `grp_in[24*g+23:24*g]`.
- R3: With source code 00, any rising or falling change on an enabled channel of groups 0 or 1 sets `pend[0]`, and one on groups 2 or 3 sets `pend[1]`. The request shows within four clock cycles of the input change.
- R4: A change on a channel whose enable bit is 0 sets no request.
- R5: A write to 0x50 sets the INT1 code from `wr_data[1:0]` and the INT2 code from `wr_data[3:2]`. Code 01 fires when C3 falls while C0 is low, or when C0 rises while C3 is high, and never otherwise. INT1 uses the pins `a_c0`/`a_c3` and INT2 uses `b_c0`/`b_c3`.
- R6: Code 10 fires only on a falling edge of the line's C0 pin (`a_c0` for INT1, `b_c0` for INT2).
- R7: Code 11 sets `pend[0]` on an `evt_zero` pulse and `pend[1]` on a `tmr_tick` pulse. These pulses are not synchronized, and the request shows after the next clock edge.
- R8: A write of any data to 0x54 clears both requests. It takes priority over a cause in the same cycle.
- R9: A held request stays set until a clear. A cause that occurs while the request is held leaves nothing behind after the clear.
- R10: `irq` is high exactly when either bit of `pend` is high.
- R11: A counter or timer pulse has no effect on a line whose code is not 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| grp_in | input | 96 | Four 24-bit asynchronous input groups |
| a_c0 | input | 1 | INT1 control pin C0 |
| a_c3 | input | 1 | INT1 control pin C3 |
| b_c0 | input | 1 | INT2 control pin C0 |
| b_c3 | input | 1 | INT2 control pin C3 |
| evt_zero | input | 1 | Event counter terminal pulse, synchronous |
| tmr_tick | input | 1 | Timer terminal pulse, synchronous |
| pend | output | 2 | Held requests: bit 0 is INT1, bit 1 is INT2 |
| irq | output | 1 | Host interrupt, the OR of both requests |

## Verification
The hardest case to reach is the one where a cause lands while a request is already held: nothing can be seen at that moment, because `pend` is already high. The bench toggles a channel while the request is held, waits for the synchronizer to drain, writes the clear and then confirms that `pend` stays low. The interlock rule is covered by walking every pair of previous and next pin levels, so the simultaneous-change combinations are included. The clear-versus-cause race is forced by putting a counter pulse in the same cycle as the clear write.

// File: rtl/sel_irq_gen.sv
module sel_irq_gen #(
  parameter int GW = 24,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [4*GW-1:0] grp_in,
  input  logic            a_c0,
  input  logic            a_c3,
  input  logic            b_c0,
  input  logic            b_c3,
  input  logic            evt_zero,
  input  logic            tmr_tick,
  output logic [1:0]      pend,
  output logic            irq
);
  localparam int NB = 4 * GW;
  localparam int NW = NB + 4;
  localparam logic [AW-1:0] A_SEL = AW'(8'h50);
  localparam logic [AW-1:0] A_CLR = AW'(8'h54);
  localparam logic [AW-1:0] A_EN  = AW'(8'h60);

  logic [NW-1:0] s1, s2, s3;
  logic [NB-1:0] en_all;
  logic [3:0]    sel;
  logic [1:0]    cause;

  wire [NW-1:0] raw = {b_c3, b_c0, a_c3, a_c0, grp_in};
  wire [NW-1:0] chg = s2 ^ s3;
  wire clr = wr_en && wr_addr == A_CLR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2;
    end

  // A change on the first sampled cycle after reset is treated as a real edge.
  for (genvar g = 0; g < 4; g++) begin : g_en
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_all[g*GW +: GW] <= '0;
      else if (wr_en && wr_addr == A_EN + AW'(4*g)) en_all[g*GW +: GW] <= wr_data[GW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel <= '0;
    else if (wr_en && wr_addr == A_SEL) sel <= wr_data[3:0];

  wire cos1 = |(chg[2*GW-1:0] & en_all[2*GW-1:0]);
  wire cos2 = |(chg[NB-1:2*GW] & en_all[NB-1:2*GW]);

  function automatic logic lock_rule(input logic c0n, c0p, c3n, c3p);
    return (c3p && !c3n && !c0n) || (!c0p && c0n && c3n);
  endfunction

  wire lk1 = lock_rule(s2[NB], s3[NB], s2[NB+1], s3[NB+1]);
  wire lk2 = lock_rule(s2[NB+2], s3[NB+2], s2[NB+3], s3[NB+3]);
  wire fe1 = s3[NB] && !s2[NB];
  wire fe2 = s3[NB+2] && !s2[NB+2];

  always_comb begin
    case (sel[1:0])
      2'b00: cause[0] = cos1;
      2'b01: cause[0] = lk1;
      2'b10: cause[0] = fe1;
      default: cause[0] = evt_zero;
    endcase
    case (sel[3:2])
      2'b00: cause[1] = cos2;
      2'b01: cause[1] = lk2;
      2'b10: cause[1] = fe2;
      default: cause[1] = tmr_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else if (clr) pend <= '0;
    else pend <= pend | cause;

  assign irq = |pend;
endmodule

module sel_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic [3:0] sel,
  input logic       evt_zero,
  input logic       tmr_tick,
  input logic [1:0] pend
);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n) clr |=> pend == 2'b00);
  a_r9_hold_int1: assert property (@(posedge clk) disable iff (!rst_n) pend[0] && !clr |=> pend[0]);
  a_r9_hold_int2: assert property (@(posedge clk) disable iff (!rst_n) pend[1] && !clr |=> pend[1]);
  a_r7_event_fires: assert property (@(posedge clk) disable iff (!rst_n)
    sel[1:0] == 2'b11 && evt_zero && !clr |=> pend[0]);
  a_r7_timer_fires: assert property (@(posedge clk) disable iff (!rst_n)
    sel[3:2] == 2'b11 && tmr_tick && !clr |=> pend[1]);
endmodule

bind sel_irq_gen sel_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(wr_en && wr_addr == 8'h54), .sel(sel),
  .evt_zero(evt_zero), .tmr_tick(tmr_tick), .pend(pend)
);

// File: tb/sim_sel_irq_gen.sv
module sim_sel_irq_gen;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [95:0] grp_in = 0;
  logic a_c0 = 0, a_c3 = 0, b_c0 = 0, b_c3 = 0, evt_zero = 0, tmr_tick = 0;
  logic [1:0] pend;
  logic irq;
  int n_cmp = 0, n_bad = 0;

  sel_irq_gen u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    settle(2); rst_n = 1; settle(1);
    chk("R1 reset pend", pend, 2'b00);
    chk("R1 reset irq", {1'b0, irq}, 2'b00);
    grp_in[0] = 1; grp_in[60] = 1; settle(5);
    chk("R1 enables off after reset", pend, 2'b00);

    for (int g = 0; g < 4; g++) wr(8'h60 + 8'(4*g), 32'hFFFFFF);
    wr(8'h54, 0); settle(1);
    for (int i = 0; i < 96; i++) begin
      grp_in[i] = ~grp_in[i]; settle(5);
      chk($sformatf("R3 cos bit %0d", i), pend, i < 48 ? 2'b01 : 2'b10);
      chk("R10 irq follows pend", {1'b0, irq}, 2'b01);
      wr(8'h54, 32'h1234); settle(1);
      chk("R8 clear", pend, 2'b00);
    end

    for (int i = 0; i < 96; i += 5) begin
      wr(8'h60 + 8'(4*(i/24)), 32'hFFFFFF & ~(32'd1 << (i % 24)));
      grp_in[i] = ~grp_in[i]; settle(5);
      chk($sformatf("R4 R2 masked bit %0d", i), pend, 2'b00);
      wr(8'h60 + 8'(4*(i/24)), 32'hFFFFFF);
    end

    for (int md = 1; md <= 2; md++) begin
      wr(8'h50, md == 1 ? 32'h5 : 32'hA);
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          logic pc0, pc3, nc0, nc3, e;
          pc0 = p[0]; pc3 = p[1]; nc0 = n[0]; nc3 = n[1];
          a_c0 = pc0; a_c3 = pc3; b_c0 = pc0; b_c3 = pc3; settle(5);
          wr(8'h54, 0); settle(1);
          a_c0 = nc0; a_c3 = nc3; b_c0 = nc0; b_c3 = nc3; settle(5);
          if (md == 1) e = (pc3 && !nc3 && !nc0) || (!pc0 && nc0 && nc3);
          else e = pc0 && !nc0;
          chk($sformatf("%s p=%0d n=%0d", md == 1 ? "R5 lock" : "R6 c0 fall", p, n), pend, {e, e});
          wr(8'h54, 0); settle(1);
        end
    end

    wr(8'h50, 0); settle(1);
    evt_zero = 1; tmr_tick = 1; settle(1); evt_zero = 0; tmr_tick = 0; settle(2);
    chk("R11 pulses ignored under code 00", pend, 2'b00);
    wr(8'h50, 32'hF);
    evt_zero = 1; settle(1); evt_zero = 0;
    chk("R7 event pulse", pend, 2'b01);
    tmr_tick = 1; settle(1); tmr_tick = 0;
    chk("R7 timer pulse", pend, 2'b11);
    wr(8'h50, 32'h3);
    tmr_tick = 1; settle(1); tmr_tick = 0;
    wr(8'h54, 0); settle(1);
    tmr_tick = 1; settle(1); tmr_tick = 0; settle(1);
    chk("R11 timer ignored under INT2 code 00", pend, 2'b00);

    @(negedge clk); wr_en = 1; wr_addr = 8'h54; evt_zero = 1;
    @(negedge clk); wr_en = 0; evt_zero = 0;
    chk("R8 clear beats same-cycle cause", pend, 2'b00);

    evt_zero = 1; settle(1); evt_zero = 0;
    wr(8'h50, 0);
    grp_in[3] = ~grp_in[3]; grp_in[70] = ~grp_in[70]; settle(5);
    chk("R9 held while cause arrives", pend, 2'b11);
    wr(8'h54, 0); settle(5);
    chk("R9 cause during hold discarded", pend, 2'b00);
    chk("R10 irq low when idle", {1'b0, irq}, 2'b00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule